// File: doc/BRIEF.md
# Backward State-Metric Store with Stage Skipping

This block manages the storage of backward state metrics for a two-pass trellis decoder. In the first pass a recursion unit delivers one metric vector per trellis stage, starting at the last stage and counting down to stage 1. Each vector is written into a stage-addressed memory, unless a per-block mask marks that stage as one whose output LLR will not be computed. In that case the vector is kept only in a pass-through register, which feeds the next recursion step. Every accepted vector goes to that register, whether or not it is also written to memory.

In the second pass a consumer steps through the stages in ascending order. An active stage reads its stored vector back from memory. A skipped stage produces no memory access at all. It still produces an output slot, tagged as skipped and carrying zero data, so the consumer's stage alignment does not slip. Two 16-bit counters record the memory writes and reads actually performed, so the saving from skipping can be measured per block.

A block starts with a one-cycle start pulse. That pulse latches the stage count and the skip mask and clears both counters.

Top module: `beta_skip_mem`

## Requirements
- R1: After reset the block is idle: both ready outputs are low, no output is valid, and both counters read 0. A start pulse latches the stage count and skip mask, clears both counters and the pass-through valid flag, and from the next cycle asserts `bwd_ready_o` with `cur_stage_o` equal to the stage count. A start pulse is honoured in any phase, including in the middle of a pass.
- R2: In the backward pass, `cur_stage_o` steps down by one for each vector accepted (`bwd_valid_i` high while `bwd_ready_o` is high). After the vector for stage 1 is accepted, `bwd_ready_o` falls and `fwd_ready_o` rises on the next cycle.
- R3: Each backward vector accepted for a stage whose mask bit is 0 is written to memory and raises the write count by one. A stage whose mask bit is 1 causes no write and leaves the write count unchanged. Bit k of the mask controls stage k+1, and a 1 means skip.
- R4: One cycle after a vector is accepted, `rec_valid_o` is high and `rec_metric_o` equals that vector, whether the stage is skipped or not.
- R5: In the forward pass, each cycle with `fwd_advance_i` high issues the current stage, starting at 1 and rising to the stage count. One cycle later `out_valid_o` is high for exactly one cycle and `out_stage_o` gives the stage issued. After the last stage, `fwd_ready_o` falls.
- R6: For an active stage, `out_metric_o` equals the vector accepted for that stage in the backward pass, `out_skip_o` is 0, and the read count rises by one.
- R7: For a skipped stage, the output slot has `out_skip_o` high and `out_metric_o` zero, and the read count is unchanged.
- R8: At the end of a block, the write count and the read count each equal the stage count minus the number of skipped stages.
- R9: Stage counts of 1 and of 64 are handled. Mask bits for stages above the stage count have no effect on the counts.
- R10: `bwd_valid_i` has no effect outside the backward pass, and `fwd_advance_i` has no effect outside the forward pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Block start pulse |
| num_stages_i | input | 7 | Number of trellis stages, 1 to 64 |
| skip_mask_i | input | 64 | Per-stage skip flags, bit k for stage k+1 |
| bwd_valid_i | input | 1 | Backward vector present |
| bwd_metric_i | input | 80 | Backward metric vector, 8 states of 10 bits |
| bwd_ready_o | output | 1 | Backward pass in progress |
| cur_stage_o | output | 7 | Stage index being processed |
| rec_valid_o | output | 1 | Pass-through register holds a vector |
| rec_metric_o | output | 80 | Most recently accepted backward vector |
| fwd_advance_i | input | 1 | Request the next forward stage |
| fwd_ready_o | output | 1 | Forward pass in progress |
| out_valid_o | output | 1 | Forward output slot valid |
| out_skip_o | output | 1 | Slot belongs to a skipped stage |
| out_stage_o | output | 7 | Stage index of the slot |
| out_metric_o | output | 80 | Stored vector, or zero for a skipped stage |
| wr_count_o | output | 16 | Memory writes in this block |
| rd_count_o | output | 16 | Memory reads in this block |

## Verification
The sweep crosses stage counts from 1 to 64 with skip masks that are all clear, all set, alternating in both phases, and irregular. All-clear and all-set masks separate the skip decision from the counters. The two alternating phases catch an off-by-one between stage index and mask bit or memory address. The irregular mask with bits set above the stage count shows whether out-of-range mask bits leak into the counts. Every stage carries a distinct vector, so a read from the wrong address is visible. A restart in the middle of a pass and stray strobes in the wrong phase check that counters clear and that inputs are ignored outside their own phase.

// File: rtl/bmem_pkg.sv
package bmem_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_BWD  = 2'd1,
    PH_FWD  = 2'd2
  } phase_e;
endpackage

// File: rtl/bmem_acc_counter.sv
module bmem_acc_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] count_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = clear_i | inc_i;
    if (clear_i) cnt_d = '0;
    else         cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/bmem_store.sv
module bmem_store #(
  parameter int DEPTH  = 64,
  parameter int WORD_W = 80,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [WORD_W-1:0] rdata_o
);
  logic [WORD_W-1:0] mem_q [DEPTH];
  logic [WORD_W-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rdata_q <= '0;
    else if (re_i) rdata_q <= mem_q[raddr_i];
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/bmem_seq.sv
module bmem_seq
  import bmem_pkg::*;
#(
  parameter int MAX_STAGES = 64,
  localparam int STG_W  = $clog2(MAX_STAGES + 1),
  localparam int ADDR_W = $clog2(MAX_STAGES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic [STG_W-1:0]      num_stages_i,
  input  logic [MAX_STAGES-1:0] skip_mask_i,
  input  logic                  bwd_valid_i,
  input  logic                  fwd_advance_i,
  output phase_e                phase_o,
  output logic [STG_W-1:0]      stage_o,
  output logic                  stage_skip_o,
  output logic [ADDR_W-1:0]     addr_o,
  output logic                  bwd_take_o,
  output logic                  fwd_take_o
);
  phase_e                phase_q, phase_d;
  logic [STG_W-1:0]      stage_q, stage_d;
  logic [STG_W-1:0]      nm_q, nm_d;
  logic [MAX_STAGES-1:0] mask_q, mask_d;
  logic [STG_W-1:0]      nm_clamped;
  logic [STG_W-1:0]      stage_m1;

  always_comb begin
    if (num_stages_i == '0)                           nm_clamped = STG_W'(1);
    else if (num_stages_i > STG_W'(MAX_STAGES))       nm_clamped = STG_W'(MAX_STAGES);
    else                                              nm_clamped = num_stages_i;
  end

  always_comb begin
    stage_m1     = stage_q - STG_W'(1);
    addr_o       = stage_m1[ADDR_W-1:0];
    stage_skip_o = mask_q[addr_o];
    bwd_take_o   = (phase_q == PH_BWD) && bwd_valid_i && !start_i;
    fwd_take_o   = (phase_q == PH_FWD) && fwd_advance_i && !start_i;
  end

  always_comb begin
    phase_d = phase_q;
    stage_d = stage_q;
    nm_d    = nm_q;
    mask_d  = mask_q;
    if (start_i) begin
      phase_d = PH_BWD;
      nm_d    = nm_clamped;
      stage_d = nm_clamped;
      mask_d  = skip_mask_i;
    end else if (bwd_take_o) begin
      if (stage_q == STG_W'(1)) begin
        phase_d = PH_FWD;
        stage_d = STG_W'(1);
      end else begin
        stage_d = stage_m1;
      end
    end else if (fwd_take_o) begin
      if (stage_q == nm_q) begin
        phase_d = PH_IDLE;
        stage_d = '0;
      end else begin
        stage_d = stage_q + STG_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      stage_q <= '0;
      nm_q    <= '0;
      mask_q  <= '0;
    end else begin
      phase_q <= phase_d;
      stage_q <= stage_d;
      if (start_i) begin
        nm_q   <= nm_d;
        mask_q <= mask_d;
      end
    end
  end

  assign phase_o = phase_q;
  assign stage_o = stage_q;

  assert_stage_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_IDLE) |-> (stage_q >= STG_W'(1) && stage_q <= nm_q));

  assert_bwd_descend_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bwd_take_o && stage_q != STG_W'(1)) |=> (stage_q == $past(stage_q) - STG_W'(1)));
endmodule

// File: rtl/beta_skip_mem.sv
module beta_skip_mem
  import bmem_pkg::*;
#(
  parameter int NUM_STATES = 8,
  parameter int METRIC_W   = 10,
  parameter int MAX_STAGES = 64,
  parameter int CNT_W      = 16,
  localparam int WORD_W = NUM_STATES * METRIC_W,
  localparam int STG_W  = $clog2(MAX_STAGES + 1),
  localparam int ADDR_W = $clog2(MAX_STAGES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic [STG_W-1:0]      num_stages_i,
  input  logic [MAX_STAGES-1:0] skip_mask_i,
  input  logic                  bwd_valid_i,
  input  logic [WORD_W-1:0]     bwd_metric_i,
  output logic                  bwd_ready_o,
  output logic [STG_W-1:0]      cur_stage_o,
  output logic                  rec_valid_o,
  output logic [WORD_W-1:0]     rec_metric_o,
  input  logic                  fwd_advance_i,
  output logic                  fwd_ready_o,
  output logic                  out_valid_o,
  output logic                  out_skip_o,
  output logic [STG_W-1:0]      out_stage_o,
  output logic [WORD_W-1:0]     out_metric_o,
  output logic [CNT_W-1:0]      wr_count_o,
  output logic [CNT_W-1:0]      rd_count_o
);
  localparam int NUM_CNT = 2;

  logic rst_meta, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_sync_n, rst_meta} <= 2'b00;
    else        {rst_sync_n, rst_meta} <= {rst_meta, 1'b1};
  end

  phase_e            phase;
  logic [STG_W-1:0]  stage;
  logic              stage_skip;
  logic [ADDR_W-1:0] addr;
  logic              bwd_take, fwd_take;
  logic              mem_we, mem_re;
  logic [WORD_W-1:0] mem_rdata;

  bmem_seq #(.MAX_STAGES(MAX_STAGES)) u_seq (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .start_i      (start_i),
    .num_stages_i (num_stages_i),
    .skip_mask_i  (skip_mask_i),
    .bwd_valid_i  (bwd_valid_i),
    .fwd_advance_i(fwd_advance_i),
    .phase_o      (phase),
    .stage_o      (stage),
    .stage_skip_o (stage_skip),
    .addr_o       (addr),
    .bwd_take_o   (bwd_take),
    .fwd_take_o   (fwd_take)
  );

  assign mem_we = bwd_take && !stage_skip;
  assign mem_re = fwd_take && !stage_skip;

  bmem_store #(.DEPTH(MAX_STAGES), .WORD_W(WORD_W)) u_store (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .we_i   (mem_we),
    .waddr_i(addr),
    .wdata_i(bwd_metric_i),
    .re_i   (mem_re),
    .raddr_i(addr),
    .rdata_o(mem_rdata)
  );

  logic [NUM_CNT-1:0] cnt_inc;
  logic [CNT_W-1:0]   cnt_val [NUM_CNT];

  assign cnt_inc = {mem_re, mem_we};

  for (genvar gi = 0; gi < NUM_CNT; gi++) begin : g_cnt
    bmem_acc_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .clear_i(start_i),
      .inc_i  (cnt_inc[gi]),
      .count_o(cnt_val[gi])
    );
  end

  assign wr_count_o = cnt_val[0];
  assign rd_count_o = cnt_val[1];

  logic              rec_valid_q, rec_valid_d, rec_en;
  logic [WORD_W-1:0] rec_metric_q;
  logic              out_valid_q, out_valid_d;
  logic              out_skip_q;
  logic [STG_W-1:0]  out_stage_q;

  always_comb begin
    rec_en      = start_i | bwd_take;
    rec_valid_d = !start_i;
    out_valid_d = fwd_take;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rec_valid_q  <= 1'b0;
      rec_metric_q <= '0;
      out_valid_q  <= 1'b0;
      out_skip_q   <= 1'b0;
      out_stage_q  <= '0;
    end else begin
      if (rec_en)   rec_valid_q  <= rec_valid_d;
      if (bwd_take) rec_metric_q <= bwd_metric_i;
      out_valid_q <= out_valid_d;
      if (fwd_take) begin
        out_skip_q  <= stage_skip;
        out_stage_q <= stage;
      end
    end
  end

  assign bwd_ready_o  = (phase == PH_BWD);
  assign fwd_ready_o  = (phase == PH_FWD);
  assign cur_stage_o  = stage;
  assign rec_valid_o  = rec_valid_q;
  assign rec_metric_o = rec_metric_q;
  assign out_valid_o  = out_valid_q;
  assign out_skip_o   = out_skip_q;
  assign out_stage_o  = out_stage_q;
  assign out_metric_o = out_skip_q ? '0 : mem_rdata;

  assert_skip_no_write_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bwd_take && stage_skip) |=> (wr_count_o == $past(wr_count_o)));

  assert_active_write_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bwd_take && !stage_skip) |=> (wr_count_o == $past(wr_count_o) + CNT_W'(1)));

  assert_rec_follow_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bwd_take |=> (rec_valid_o && rec_metric_o == $past(bwd_metric_i)));

  assert_out_after_adv_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_valid_o |-> $past(fwd_ready_o && fwd_advance_i && !start_i));

  assert_skip_no_read_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid_o && out_skip_o) |-> (rd_count_o == $past(rd_count_o)));

  assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_count_o <= CNT_W'(MAX_STAGES)) && (rd_count_o <= wr_count_o || bwd_ready_o));
endmodule

// File: tb/tb_beta_skip_mem.sv
module tb_beta_skip_mem;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [6:0]  num_stages_i;
  logic [63:0] skip_mask_i;
  logic        bwd_valid_i;
  logic [79:0] bwd_metric_i;
  logic        bwd_ready_o;
  logic [6:0]  cur_stage_o;
  logic        rec_valid_o;
  logic [79:0] rec_metric_o;
  logic        fwd_advance_i;
  logic        fwd_ready_o;
  logic        out_valid_o;
  logic        out_skip_o;
  logic [6:0]  out_stage_o;
  logic [79:0] out_metric_o;
  logic [15:0] wr_count_o;
  logic [15:0] rd_count_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  beta_skip_mem dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .num_stages_i(num_stages_i),
    .skip_mask_i(skip_mask_i), .bwd_valid_i(bwd_valid_i), .bwd_metric_i(bwd_metric_i),
    .bwd_ready_o(bwd_ready_o), .cur_stage_o(cur_stage_o), .rec_valid_o(rec_valid_o),
    .rec_metric_o(rec_metric_o), .fwd_advance_i(fwd_advance_i), .fwd_ready_o(fwd_ready_o),
    .out_valid_o(out_valid_o), .out_skip_o(out_skip_o), .out_stage_o(out_stage_o),
    .out_metric_o(out_metric_o), .wr_count_o(wr_count_o), .rd_count_o(rd_count_o)
  );

  function automatic logic [79:0] vec_of(int blk, int stg);
    logic [79:0] v;
    for (int k = 0; k < 8; k++) v[k*10 +: 10] = 10'((stg * 37 + blk * 101 + k * 13) & 1023);
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic run_block(input int blk, input int nm, input logic [63:0] mask);
    int wexp, rexp, pop;
    logic [63:0] low;
    logic [79:0] e;
    bit sk;
    @(negedge clk);
    start_i = 1'b1; num_stages_i = 7'(nm); skip_mask_i = mask;
    @(negedge clk);
    start_i = 1'b0;
    chk(bwd_ready_o && !fwd_ready_o, "R1 ready after start", 80'(bwd_ready_o), 80'd1);
    chk(cur_stage_o == 7'(nm), "R1 first stage", 80'(cur_stage_o), 80'(nm));
    chk(wr_count_o == 0 && rd_count_o == 0, "R1 counters cleared", 80'(wr_count_o), 80'd0);
    chk(!rec_valid_o, "R1 pass-through cleared", 80'(rec_valid_o), 80'd0);
    fwd_advance_i = 1'b1;
    @(negedge clk);
    fwd_advance_i = 1'b0;
    chk(!out_valid_o && cur_stage_o == 7'(nm), "R10 advance ignored in backward pass", 80'(out_valid_o), 80'd0);
    wexp = 0;
    for (int s = nm; s >= 1; s--) begin
      chk(cur_stage_o == 7'(s), "R2 descending stage", 80'(cur_stage_o), 80'(s));
      bwd_valid_i = 1'b1; bwd_metric_i = vec_of(blk, s);
      if (!mask[s-1]) wexp++;
      @(negedge clk);
      bwd_valid_i = 1'b0;
      e = vec_of(blk, s);
      chk(rec_valid_o && rec_metric_o == e, "R4 pass-through", rec_metric_o, e);
      chk(wr_count_o == 16'(wexp), "R3 write count", 80'(wr_count_o), 80'(wexp));
    end
    chk(!bwd_ready_o && fwd_ready_o, "R2 phase change", 80'({bwd_ready_o, fwd_ready_o}), 80'b01);
    chk(cur_stage_o == 7'd1, "R5 forward starts at 1", 80'(cur_stage_o), 80'd1);
    bwd_valid_i = 1'b1; bwd_metric_i = '1;
    @(negedge clk);
    bwd_valid_i = 1'b0;
    e = vec_of(blk, 1);
    chk(wr_count_o == 16'(wexp) && rec_metric_o == e, "R10 backward strobe ignored", rec_metric_o, e);
    rexp = 0;
    for (int s = 1; s <= nm; s++) begin
      fwd_advance_i = 1'b1;
      @(negedge clk);
      fwd_advance_i = 1'b0;
      sk = mask[s-1];
      if (!sk) rexp++;
      chk(out_valid_o && out_stage_o == 7'(s), "R5 slot stage", 80'(out_stage_o), 80'(s));
      chk(out_skip_o == sk, sk ? "R7 skip tag" : "R6 skip tag", 80'(out_skip_o), 80'(sk));
      e = sk ? 80'd0 : vec_of(blk, s);
      chk(out_metric_o == e, sk ? "R7 zero data" : "R6 stored data", out_metric_o, e);
      chk(rd_count_o == 16'(rexp), sk ? "R7 read count" : "R6 read count", 80'(rd_count_o), 80'(rexp));
    end
    @(negedge clk);
    chk(!out_valid_o && !fwd_ready_o, "R5 pass ends", 80'({out_valid_o, fwd_ready_o}), 80'd0);
    low = (nm >= 64) ? '1 : ((64'd1 << nm) - 64'd1);
    pop = $countones(mask & low);
    chk(wr_count_o == 16'(nm - pop) && rd_count_o == 16'(nm - pop), "R8 totals",
        80'({wr_count_o, rd_count_o}), 80'({16'(nm - pop), 16'(nm - pop)}));
    if (nm == 1 || nm == 64 || (mask & ~low) != 0)
      chk(wr_count_o == 16'(nm - pop), "R9 edge count or upper mask bits", 80'(wr_count_o), 80'(nm - pop));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int nms [7] = '{1, 2, 3, 7, 8, 33, 64};
    logic [63:0] masks [5] = '{64'h0, '1, 64'hAAAA_AAAA_AAAA_AAAA,
                               64'h5555_5555_5555_5555, 64'h9E37_79B9_7F4A_7C15};
    int blk;
    rst_n = 1'b0; start_i = 1'b0; num_stages_i = '0; skip_mask_i = '0;
    bwd_valid_i = 1'b0; bwd_metric_i = '0; fwd_advance_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!bwd_ready_o && !fwd_ready_o && !out_valid_o && !rec_valid_o, "R1 idle after reset",
        80'({bwd_ready_o, fwd_ready_o, out_valid_o, rec_valid_o}), 80'd0);
    chk(wr_count_o == 0 && rd_count_o == 0, "R1 counters zero after reset", 80'(wr_count_o), 80'd0);
    bwd_valid_i = 1'b1; fwd_advance_i = 1'b1;
    @(negedge clk);
    bwd_valid_i = 1'b0; fwd_advance_i = 1'b0;
    @(negedge clk);
    chk(wr_count_o == 0 && !out_valid_o && !rec_valid_o, "R10 strobes ignored when idle", 80'(wr_count_o), 80'd0);

    start_i = 1'b1; num_stages_i = 7'd8; skip_mask_i = '0;
    @(negedge clk);
    start_i = 1'b0;
    for (int s = 8; s > 5; s--) begin
      bwd_valid_i = 1'b1; bwd_metric_i = vec_of(99, s);
      @(negedge clk);
    end
    bwd_valid_i = 1'b0;
    chk(wr_count_o == 16'd3, "R3 partial write count", 80'(wr_count_o), 80'd3);
    start_i = 1'b1; num_stages_i = 7'd5;
    @(negedge clk);
    start_i = 1'b0;
    chk(wr_count_o == 0 && cur_stage_o == 7'd5 && bwd_ready_o, "R1 restart mid-pass",
        80'({wr_count_o, cur_stage_o}), 80'({16'd0, 7'd5}));

    blk = 0;
    foreach (nms[i]) begin
      foreach (masks[j]) begin
        run_block(blk, nms[i], masks[j]);
        blk++;
      end
    end
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule